// File: doc/BRIEF.md
# Q15 Scaled Multiply-Accumulate Unit

This block is a signed fixed-point multiply-accumulate datapath for 16-bit fractional words. Each word has one sign bit and fifteen fraction bits. Every cycle, the block can multiply a sample by a coefficient. The sample is first reduced by an arithmetic right shift of a programmable amount. The 32-bit product has two sign bits in its top positions. The block sign-extends that product into a 40-bit accumulator, which holds 8 guard bits above the product. Sums keep their full precision in the accumulator and wrap silently within its 40 bits.

A store request converts the accumulator back to a 16-bit fractional word. First it shifts the accumulator left by the same programmable amount, which undoes the pre-scaling. It then takes the bits that sit 15 places above the product's least significant bit. Bits below that point are discarded. If the value does not fit in 16 bits, the output clamps to the nearest extreme. A sticky flag records every clamp. Software can run typical or worst-case data, watch the flag and choose a scaling amount. Sequencing of taps and coefficient storage belong to the surrounding logic.

Top module: `q15_mac`

## Requirements
- R1: After reset, result_o reads 0x0000, ovf_o reads 0 and the accumulator holds zero.
- R2: When start_i is high, the accumulator is loaded with the current product and its previous sum is dropped. start_i wins over acc_i.
- R3: When acc_i is high and start_i is low, the product is added to the 40-bit accumulator. The sum wraps modulo 2^40. No overflow is flagged at add time.
- R4: A store delivers bits [30:15] of the accumulator shifted left by shift_i. Dropped low bits are truncated toward negative infinity, so a sum of -1 LSB of the product stores as 0xFFFF.
- R5: A store whose value exceeds +32767 gives 0x7FFF. A store whose value is below -32768 gives 0x8000.
- R6: A store of the single product 0x8000 × 0x8000 at shift 0 gives 0x7FFF, not 0x8000.
- R7: Before the multiply, the sample is arithmetically shifted right by shift_i, where shift_i is between 0 and 15.
- R8: The post-scale left shift is applied to the full 40-bit accumulator before narrowing, and saturation is decided on that shifted value.
- R9: ovf_o is set by any store that saturates, and stays set until clear_i. clear_i wins over a saturating store in the same cycle.
- R10: store_i samples the accumulator as it was before that cycle's update. result_o changes only on a store. The accumulator changes only on start_i or acc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the accumulator with the current product |
| acc_i | input | 1 | Add the current product to the accumulator |
| store_i | input | 1 | Convert the accumulator and register it on result_o |
| clear_i | input | 1 | Clear the sticky overflow flag |
| shift_i | input | 4 | Pre-scale right shift and post-scale left shift amount |
| sample_i | input | 16 | Signed Q15 sample |
| coeff_i | input | 16 | Signed Q15 coefficient |
| result_o | output | 16 | Last stored Q15 result |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
A start or accumulate appears in the accumulator one edge after it is applied. A later store reads that sum, and its result_o and ovf_o are due on the edge that samples the store. The bench drives each operation just after a rising edge. It updates its own accumulator and flag model in the same step, then compares result_o and ovf_o one time unit after the next rising edge. A store issued in the same cycle as an accumulate is therefore expected to show the sum from before that accumulate.

// File: rtl/q15_mac_pkg.sv
package q15_mac_pkg;
  typedef struct packed {
    logic start;
    logic acc;
    logic store;
    logic clear;
  } mac_ctrl_t;
endpackage

// File: rtl/q15_premul.sv
module q15_premul #(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 4,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [DATA_W-1:0]  coeff_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [PROD_W-1:0]  prod_o
);
  logic signed [DATA_W-1:0] s_scaled;
  logic signed [PROD_W-1:0] a_x, b_x;

  // pre-scale: arithmetic right shift keeps sign
  assign s_scaled = $signed(sample_i) >>> shift_i;
  assign a_x = s_scaled;
  assign b_x = $signed(coeff_i);
  assign prod_o = a_x * b_x;
endmodule

// File: rtl/q15_accum.sv
module q15_accum #(
  parameter int PROD_W  = 32,
  parameter int GUARD_W = 8,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              acc_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] prod_ext;
  assign prod_ext = {{GUARD_W{prod_i[PROD_W-1]}}, prod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (start_i) acc_o <= prod_ext;
    else if (acc_i)   acc_o <= acc_o + prod_ext; // wraps in ACC_W
  end

  a_r10_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !acc_i) |=> $stable(acc_o));
  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (acc_o[PROD_W-1:0] == $past(prod_i)));
endmodule

// File: rtl/q15_store_sat.sv
module q15_store_sat #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 40,
  parameter int SHIFT_W = 4,
  localparam int SH_MAX = (1 << SHIFT_W) - 1,
  localparam int WIDE_W = ACC_W + SH_MAX,
  localparam int FRAC   = DATA_W - 1,
  localparam int TOP_LO = FRAC + DATA_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               store_i,
  input  logic               clear_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ACC_W-1:0]   acc_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               ovf_o
);
  localparam logic [DATA_W-1:0] Q_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] Q_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [WIDE_W-1:0]        wide;
  logic [WIDE_W-TOP_LO-1:0] top;
  logic                     sat, neg;
  logic [DATA_W-1:0]        conv;

  // post-scale on the full accumulator, then narrow
  assign wide = {{SH_MAX{acc_i[ACC_W-1]}}, acc_i} << shift_i;
  assign top  = wide[WIDE_W-1:TOP_LO];
  assign neg  = wide[WIDE_W-1];
  assign sat  = !((&top) || !(|top));
  assign conv = sat ? (neg ? Q_MIN : Q_MAX) : wide[TOP_LO:FRAC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      result_o <= '0;
    else if (store_i) result_o <= conv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_o <= 1'b0;
    else if (clear_i)           ovf_o <= 1'b0;
    else if (store_i && sat)    ovf_o <= 1'b1;
  end

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |=> $stable(result_o));
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clear_i) |=> ovf_o);
  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ovf_o);
  a_r5_sat_clamps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && sat) |=> ((result_o == Q_MAX) || (result_o == Q_MIN)));
endmodule

// File: rtl/q15_mac.sv
module q15_mac
  import q15_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  parameter int SHIFT_W = 4,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               acc_i,
  input  logic               store_i,
  input  logic               clear_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [DATA_W-1:0]  coeff_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               ovf_o
);
  mac_ctrl_t         ctrl;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc;

  assign ctrl = '{start: start_i, acc: acc_i, store: store_i, clear: clear_i};

  q15_premul #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_mul (
    .sample_i(sample_i), .coeff_i(coeff_i), .shift_i(shift_i), .prod_o(prod)
  );

  q15_accum #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ctrl.start), .acc_i(ctrl.acc),
    .prod_i(prod), .acc_o(acc)
  );

  q15_store_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .store_i(ctrl.store), .clear_i(ctrl.clear),
    .shift_i(shift_i), .acc_i(acc), .result_o(result_o), .ovf_o(ovf_o)
  );

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (result_o == '0 && !ovf_o));
endmodule

// File: tb/sim_q15_mac.sv
module sim_q15_mac;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, acc_en = 0, store = 0, clr = 0;
  logic [3:0]  sh = 0;
  logic [15:0] smp = 0, cof = 0;
  logic [15:0] result;
  logic        ovf;

  int total = 0, bad = 0;
  logic signed [39:0] m_acc;
  logic [15:0] m_res;
  logic        m_ovf;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  q15_mac u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_i(acc_en), .store_i(store),
    .clear_i(clr), .shift_i(sh), .sample_i(smp), .coeff_i(cof),
    .result_o(result), .ovf_o(ovf)
  );

  function automatic logic signed [31:0] f_prod(logic [15:0] s, logic [15:0] c, logic [3:0] k);
    logic signed [15:0] ss;
    logic signed [31:0] a, b;
    ss = $signed(s) >>> k;
    a = ss;
    b = $signed(c);
    return a * b;
  endfunction

  // returns {sat, value}
  function automatic logic [16:0] f_store(logic signed [39:0] a, logic [3:0] k);
    logic signed [54:0] w, v;
    w = a;
    w = w <<< k;
    v = w >>> 15;
    if (v > 55'sd32767)       return {1'b1, 16'h7FFF};
    else if (v < -55'sd32768) return {1'b1, 16'h8000};
    else                      return {1'b0, v[15:0]};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic st, logic ac, logic so, logic cl, logic [3:0] k,
                      logic [15:0] s, logic [15:0] c, string tag);
    logic signed [31:0] p;
    logic [16:0] r;
    start = st; acc_en = ac; store = so; clr = cl; sh = k; smp = s; cof = c;
    p = f_prod(s, c, k);
    r = f_store(m_acc, k);  // R10: store sees pre-update sum
    if (so) m_res = r[15:0];
    if (cl) m_ovf = 0;
    else if (so && r[16]) m_ovf = 1;
    if (st) m_acc = p;
    else if (ac) m_acc = m_acc + p;
    @(posedge clk); #1;
    check({tag, " result"}, result, m_res);
    check({tag, " ovf"}, {15'd0, ovf}, {15'd0, m_ovf});
    start = 0; acc_en = 0; store = 0; clr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    m_acc = 0; m_res = 0; m_ovf = 0;
    #(CLK_P * 2 + 1);
    check("R1 result", result, 16'h0000);
    check("R1 ovf", {15'd0, ovf}, 16'h0000);
    rst_n = 1;
    @(posedge clk); #1;
    step(0, 0, 1, 0, 0, 0, 0, "R1 acc zero");

    // R6: -1 x -1
    step(1, 0, 0, 0, 0, 16'h8000, 16'h8000, "R6 load");
    step(0, 0, 1, 0, 0, 0, 0, "R6 store");
    check("R6 value", result, 16'h7FFF);
    check("R9 set", {15'd0, ovf}, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 0, "R9 sticky");
    step(0, 0, 0, 1, 0, 0, 0, "R9 clear");
    // R9 clear wins over saturating store
    step(0, 0, 1, 1, 0, 0, 0, "R9 clear priority");
    check("R9 clear priority flag", {15'd0, ovf}, 16'h0000);

    // R4 truncation toward -inf
    step(1, 0, 0, 0, 0, 16'hFFFF, 16'h0001, "R4 load");
    step(0, 0, 1, 0, 0, 0, 0, "R4 store");
    check("R4 trunc", result, 16'hFFFF);

    // R5 negative saturation, R2 start overrides acc
    step(1, 0, 0, 0, 0, 16'h8000, 16'h7FFF, "R5 load");
    step(0, 1, 0, 0, 0, 16'h8000, 16'h7FFF, "R5 acc");
    step(0, 0, 1, 0, 0, 0, 0, "R5 store");
    check("R5 neg sat", result, 16'h8000);
    step(1, 1, 0, 1, 0, 16'h0100, 16'h0100, "R2 start wins");
    step(0, 0, 1, 0, 0, 0, 0, "R2 store");

    // R7/R8 matched scaling
    step(1, 0, 0, 0, 4'd3, 16'h7000, 16'h6000, "R7 load");
    step(0, 1, 0, 0, 4'd3, 16'h5000, 16'h7000, "R7 acc");
    step(0, 0, 1, 0, 4'd3, 0, 0, "R8 store");
    step(0, 0, 1, 0, 4'd15, 0, 0, "R8 big shift sat");

    // R3 wrap: 512 x 2^30 = 2^39 wraps negative
    step(1, 0, 0, 1, 0, 16'h8000, 16'h8000, "R3 load");
    for (int i = 0; i < 511; i++) step(0, 1, 0, 0, 0, 16'h8000, 16'h8000, "R3 acc");
    check("R3 no flag on add", {15'd0, ovf}, 16'h0000);
    step(0, 0, 1, 0, 0, 0, 0, "R3 wrap store");
    check("R3 wrapped", result, 16'h8000);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1] & r[2], r[3], r[4] & r[5], r[6] & r[7] & r[8],
           r[9] ? 4'($urandom_range(0, 15)) : 4'd0,
           16'($urandom), 16'($urandom), "R2-R10 rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule